// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a small synchronous single-port memory of one-bit cells. It serves as a target for memory self-test logic. A self-test engine drives the functional port with an address, a write strobe, a read strobe and a data bit. Read data comes back from a register one clock after the read strobe.

A separate set of configuration inputs can arm a single functional defect in the array. The defect is described by a victim address, an aggressor address, a fault kind and a polarity bit. The possible defects are:

- a cell stuck at a fixed value;
- a cell that refuses one transition direction;
- a coupling fault in which an aggressor transition inverts the victim or forces it to a value;
- a dynamic coupling fault in which any access to the aggressor forces the victim;
- a decoder fault in which one address lands on another.

When the enable bit is low, the array behaves as an ideal memory. This lets a test engine be checked first against a clean array, then against each armed defect in turn. The configuration is only changed while the functional port is idle.

Top module: `fault_ram`

## Requirements
- R1: After reset every cell holds 0 and `rdata` is 0.
- R2: With `flt_en` low, a read returns the last value written to that address. `rdata` changes on the clock edge where `rd_en` is sampled high and keeps its value while `rd_en` is low.
- R3: When `rd_en` and `wr_en` are both high in one cycle, `rdata` returns the value stored before that write, and the write still takes effect.
- R4: Stuck-at fault (`flt_kind`=0): reads of the victim address return `flt_pol`, whatever was written to it.
- R5: Transition fault (`flt_kind`=1): a write of `flt_pol` to the victim while it holds the opposite value leaves the cell unchanged. A write of the opposite value still succeeds.
- R6: Inversion coupling (`flt_kind`=2): a write that changes the stored value of the aggressor complements the victim on the same edge. A write that leaves the aggressor's value unchanged does not disturb the victim.
- R7: Idempotent coupling (`flt_kind`=3): a write that changes the aggressor's stored value sets the victim to `flt_pol` on the same edge. The victim stays directly writable.
- R8: Dynamic coupling (`flt_kind`=4): any read or write of the aggressor sets the victim to `flt_pol` on the same edge.
- R9: Decoder fault (`flt_kind`=5): reads and writes of the aggressor address act on the victim cell. The aggressor's own cell is left untouched.
- R10: With `flt_en` low, every fault kind is inert. Codes 6 and 7 arm no fault. For the coupling kinds the aggressor must differ from the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Functional address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 1 | Write data bit |
| rdata | output | 1 | Registered read data |
| flt_en | input | 1 | Arms the configured fault |
| flt_kind | input | 3 | Fault kind code |
| flt_pol | input | 1 | Fault polarity / forced value |
| flt_victim | input | ADDR_W | Victim address (decoder target) |
| flt_aggr | input | ADDR_W | Aggressor address (decoder source) |

## Verification
On every cycle, the bound checker verifies several cell-level effects: the ideal write path, hold of `rdata` between reads, the stuck read value, the blocked transition, and the victim update for inversion, dynamic and decoder faults. It checks these against the stored cells on the edge after the trigger.

Some behaviours depend on what happened to a cell earlier, and only the directed scenarios can show them. Examples are that a non-changing aggressor write leaves the victim alone, that an idempotent victim stays writable between triggers, that a decoder alias leaves the source cell untouched once the fault is disarmed, and that read-before-write ordering holds in a shared cycle.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;
  typedef enum logic [2:0] {
    FK_STUCK  = 3'd0,
    FK_TRANS  = 3'd1,
    FK_CINV   = 3'd2,
    FK_CIDEM  = 3'd3,
    FK_CDYN   = 3'd4,
    FK_DECODE = 3'd5
  } fault_kind_e;
endpackage

// File: rtl/fr_addr_map.sv
module fr_addr_map #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic [ADDR_W-1:0] phys_o
);
  import fault_ram_pkg::*;

  always_comb begin
    phys_o = addr_i;
    if (en_i && (fault_kind_e'(kind_i) == FK_DECODE) && (addr_i == src_i)) begin
      phys_o = dst_i;
    end
  end
endmodule

// File: rtl/fr_fault_ctl.sv
module fr_fault_ctl #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] phys_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              wdata_i,
  input  logic [DEPTH-1:0]  cell_i,
  input  logic              en_i,
  input  logic [2:0]        kind_i,
  input  logic              pol_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggr_i,
  output logic [DEPTH-1:0]  we_o,
  output logic [DEPTH-1:0]  val_o
);
  import fault_ram_pkg::*;

  fault_kind_e kind;
  logic        hit_aggr;
  logic        aggr_flip;
  logic        blocked;

  always_comb begin
    kind      = fault_kind_e'(kind_i);
    hit_aggr  = en_i && (phys_i == aggr_i);
    aggr_flip = hit_aggr && wr_en_i && (wdata_i != cell_i[aggr_i]);
    blocked   = en_i && (kind == FK_TRANS) && (phys_i == victim_i) &&
                (wdata_i == pol_i) && (cell_i[victim_i] != pol_i);

    we_o  = '0;
    val_o = cell_i;

    if (wr_en_i && !blocked) begin
      we_o[phys_i]  = 1'b1;
      val_o[phys_i] = wdata_i;
    end

    if (kind == FK_CINV && aggr_flip) begin
      we_o[victim_i]  = 1'b1;
      val_o[victim_i] = ~cell_i[victim_i];
    end else if (kind == FK_CIDEM && aggr_flip) begin
      we_o[victim_i]  = 1'b1;
      val_o[victim_i] = pol_i;
    end else if (kind == FK_CDYN && hit_aggr && (wr_en_i || rd_en_i)) begin
      we_o[victim_i]  = 1'b1;
      val_o[victim_i] = pol_i;
    end
  end
endmodule

// File: rtl/fr_cell_array.sv
module fr_cell_array #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] we_i,
  input  logic [DEPTH-1:0] val_i,
  output logic [DEPTH-1:0] cell_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_o[i] <= 1'b0;
      end else if (we_i[i]) begin
        cell_o[i] <= val_i[i];
      end
    end
  end
endmodule

// File: rtl/fault_ram.sv
module fault_ram #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              wdata,
  output logic              rdata,
  input  logic              flt_en,
  input  logic [2:0]        flt_kind,
  input  logic              flt_pol,
  input  logic [ADDR_W-1:0] flt_victim,
  input  logic [ADDR_W-1:0] flt_aggr
);
  import fault_ram_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] phys;
  logic [DEPTH-1:0]  cell_q;
  logic [DEPTH-1:0]  cell_we;
  logic [DEPTH-1:0]  cell_val;
  logic              rd_bit;
  logic              rdata_d;
  logic              rdata_q;

  fr_addr_map #(.ADDR_W(ADDR_W)) map_i (
    .addr_i (addr),
    .en_i   (flt_en),
    .kind_i (flt_kind),
    .src_i  (flt_aggr),
    .dst_i  (flt_victim),
    .phys_o (phys)
  );

  fr_fault_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .phys_i   (phys),
    .wr_en_i  (wr_en),
    .rd_en_i  (rd_en),
    .wdata_i  (wdata),
    .cell_i   (cell_q),
    .en_i     (flt_en),
    .kind_i   (flt_kind),
    .pol_i    (flt_pol),
    .victim_i (flt_victim),
    .aggr_i   (flt_aggr),
    .we_o     (cell_we),
    .val_o    (cell_val)
  );

  fr_cell_array #(.DEPTH(DEPTH)) arr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cell_we),
    .val_i  (cell_val),
    .cell_o (cell_q)
  );

  always_comb begin
    rd_bit = cell_q[phys];
    if (flt_en && (fault_kind_e'(flt_kind) == FK_STUCK) && (phys == flt_victim)) begin
      rd_bit = flt_pol;
    end
    rdata_d = rd_en ? rd_bit : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wdata,
  input logic              rdata,
  input logic              flt_en,
  input logic [2:0]        flt_kind,
  input logic              flt_pol,
  input logic [ADDR_W-1:0] flt_victim,
  input logic [ADDR_W-1:0] flt_aggr,
  input logic [DEPTH-1:0]  cell_q
);
  assert_ideal_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_en && wr_en) |=> cell_q[$past(addr)] == $past(wdata));

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_stuck_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && flt_en && flt_kind == 3'd0 && addr == flt_victim) |=> rdata == $past(flt_pol));

  assert_trans_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flt_en && flt_kind == 3'd1 && addr == flt_victim &&
     wdata == flt_pol && cell_q[flt_victim] != flt_pol)
    |=> cell_q[$past(flt_victim)] == $past(cell_q[flt_victim]));

  assert_inv_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flt_en && flt_kind == 3'd2 && addr == flt_aggr &&
     flt_aggr != flt_victim && wdata != cell_q[flt_aggr])
    |=> cell_q[$past(flt_victim)] != $past(cell_q[flt_victim]));

  assert_dyn_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && flt_en && flt_kind == 3'd4 && addr == flt_aggr &&
     flt_aggr != flt_victim)
    |=> cell_q[$past(flt_victim)] == $past(flt_pol));

  assert_alias_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flt_en && flt_kind == 3'd5 && addr == flt_aggr)
    |=> cell_q[$past(flt_victim)] == $past(wdata));
endmodule

bind fault_ram fault_ram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .flt_en     (flt_en),
  .flt_kind   (flt_kind),
  .flt_pol    (flt_pol),
  .flt_victim (flt_victim),
  .flt_aggr   (flt_aggr),
  .cell_q     (cell_q)
);

// File: tb/fault_ram_tb_top.sv
module fault_ram_tb_top;
  localparam int AW = 4;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en;
  logic          rd_en;
  logic          wdata;
  logic          rdata;
  logic          flt_en;
  logic [2:0]    flt_kind;
  logic          flt_pol;
  logic [AW-1:0] flt_victim;
  logic [AW-1:0] flt_aggr;

  int checks;
  int errors;

  fault_ram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .flt_en(flt_en), .flt_kind(flt_kind),
    .flt_pol(flt_pol), .flt_victim(flt_victim), .flt_aggr(flt_aggr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_fault(input logic en, input logic [2:0] kind, input logic pol,
                           input logic [AW-1:0] vic, input logic [AW-1:0] agg);
    @(negedge clk);
    flt_en = en; flt_kind = kind; flt_pol = pol; flt_victim = vic; flt_aggr = agg;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset();
    logic v;
    check("R1 rdata after reset", rdata, 1'b0);
    rd(4'd3, v);  check("R1 cell 3 after reset", v, 1'b0);
    rd(4'd15, v); check("R1 cell 15 after reset", v, 1'b0);
  endtask

  task automatic t_ideal();
    logic v;
    for (int i = 0; i < 16; i++) wr(i[AW-1:0], i[0] ^ i[2]);
    for (int i = 0; i < 16; i++) begin
      rd(i[AW-1:0], v);
      check("R2 ideal readback", v, i[0] ^ i[2]);
    end
    rd(4'd1, v);
    @(negedge clk); addr = 4'd0;
    @(negedge clk);
    check("R2 rdata held without rd_en", rdata, 1'b1);
  endtask

  task automatic t_rbw();
    logic v;
    wr(4'd5, 1'b0);
    @(negedge clk);
    addr = 4'd5; wdata = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R3 read returns old value", rdata, 1'b0);
    rd(4'd5, v); check("R3 write still lands", v, 1'b1);
  endtask

  task automatic t_stuck();
    logic v;
    set_fault(1'b1, 3'd0, 1'b1, 4'd7, 4'd0);
    wr(4'd7, 1'b0); rd(4'd7, v); check("R4 stuck-at-1", v, 1'b1);
    set_fault(1'b1, 3'd0, 1'b0, 4'd7, 4'd0);
    wr(4'd7, 1'b1); rd(4'd7, v); check("R4 stuck-at-0", v, 1'b0);
    wr(4'd6, 1'b1); rd(4'd6, v); check("R4 neighbour unaffected", v, 1'b1);
    set_fault(1'b0, 3'd0, 1'b0, 4'd7, 4'd0);
    rd(4'd7, v); check("R10 disarmed stuck shows stored", v, 1'b1);
  endtask

  task automatic t_trans();
    logic v;
    set_fault(1'b0, 3'd1, 1'b1, 4'd2, 4'd0);
    wr(4'd2, 1'b1);
    set_fault(1'b1, 3'd1, 1'b1, 4'd2, 4'd0);
    wr(4'd2, 1'b0); rd(4'd2, v); check("R5 allowed direction", v, 1'b0);
    wr(4'd2, 1'b1); rd(4'd2, v); check("R5 blocked direction", v, 1'b0);
    set_fault(1'b0, 3'd1, 1'b1, 4'd2, 4'd0);
    wr(4'd2, 1'b1); rd(4'd2, v); check("R10 disarmed transition", v, 1'b1);
  endtask

  task automatic t_inv();
    logic v;
    set_fault(1'b0, 3'd2, 1'b0, 4'd9, 4'd4);
    wr(4'd4, 1'b0); wr(4'd9, 1'b0);
    set_fault(1'b1, 3'd2, 1'b0, 4'd9, 4'd4);
    wr(4'd4, 1'b0); rd(4'd9, v); check("R6 no aggressor change", v, 1'b0);
    wr(4'd4, 1'b1); rd(4'd9, v); check("R6 rise inverts victim", v, 1'b1);
    wr(4'd4, 1'b0); rd(4'd9, v); check("R6 fall inverts victim", v, 1'b0);
    rd(4'd4, v); check("R6 aggressor holds its write", v, 1'b0);
  endtask

  task automatic t_idem();
    logic v;
    set_fault(1'b0, 3'd3, 1'b1, 4'd10, 4'd11);
    wr(4'd10, 1'b0); wr(4'd11, 1'b0);
    set_fault(1'b1, 3'd3, 1'b1, 4'd10, 4'd11);
    wr(4'd11, 1'b1); rd(4'd10, v); check("R7 victim forced", v, 1'b1);
    wr(4'd10, 1'b0); rd(4'd10, v); check("R7 victim writable", v, 1'b0);
    wr(4'd11, 1'b1); rd(4'd10, v); check("R7 no change no force", v, 1'b0);
    wr(4'd11, 1'b0); rd(4'd10, v); check("R7 fall forces victim", v, 1'b1);
  endtask

  task automatic t_dyn();
    logic v;
    set_fault(1'b0, 3'd4, 1'b0, 4'd12, 4'd13);
    wr(4'd12, 1'b1); wr(4'd13, 1'b0);
    set_fault(1'b1, 3'd4, 1'b0, 4'd12, 4'd13);
    rd(4'd13, v); rd(4'd12, v); check("R8 read of aggressor forces", v, 1'b0);
    wr(4'd12, 1'b1);
    wr(4'd13, 1'b0); rd(4'd12, v); check("R8 write of aggressor forces", v, 1'b0);
    set_fault(1'b1, 3'd4, 1'b1, 4'd12, 4'd13);
    rd(4'd13, v); rd(4'd12, v); check("R8 force to one", v, 1'b1);
  endtask

  task automatic t_dec();
    logic v;
    set_fault(1'b0, 3'd5, 1'b0, 4'd14, 4'd1);
    wr(4'd1, 1'b0); wr(4'd14, 1'b0);
    set_fault(1'b1, 3'd5, 1'b0, 4'd14, 4'd1);
    wr(4'd1, 1'b1); rd(4'd14, v); check("R9 write lands on target", v, 1'b1);
    rd(4'd1, v); check("R9 read returns target", v, 1'b1);
    set_fault(1'b0, 3'd5, 1'b0, 4'd14, 4'd1);
    rd(4'd1, v); check("R9 source cell untouched", v, 1'b0);
  endtask

  task automatic t_unused_code();
    logic v;
    set_fault(1'b1, 3'd7, 1'b1, 4'd8, 4'd0);
    wr(4'd8, 1'b0); rd(4'd8, v); check("R10 code 7 inert", v, 1'b0);
    set_fault(1'b0, 3'd0, 1'b0, 4'd0, 4'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = 1'b0;
    flt_en = 1'b0; flt_kind = 3'd0; flt_pol = 1'b0; flt_victim = '0; flt_aggr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_ideal();
    t_rbw();
    t_stuck();
    t_trans();
    t_inv();
    t_idem();
    t_dyn();
    t_dec();
    t_unused_code();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule